// File: doc/BRIEF.md
# Manchester Line Transmitter

This block turns one parallel byte into a self-clocking serial waveform on a single wire. Each bit cell has a guaranteed transition at its centre. A one is sent as a high first half followed by a low second half. A zero is sent as a low first half followed by a high second half.

Internally a shift register presents one bit per cell and changes only at cell boundaries. The line is that bit XORed with a cell-rate square wave, which is low in the first half of each cell and high in the second. Every frame is preceded by a single zero cell, so a receiver can find the phase of the centre transitions before the payload arrives. The cell length is a parameter counted in system clocks.

A client raises `startReq` with the byte on `txByte`. The request is taken on the first clock edge where the block is idle. `busy` covers the whole frame. `done` marks the cycle after the last cell.

Top module: `manchester_tx`

## Requirements
- R1: A payload bit of value 1 is driven high for the first BIT_CLKS/2 clocks of its cell and low for the remaining BIT_CLKS/2 clocks.
- R2: A payload bit of value 0 is driven low for the first BIT_CLKS/2 clocks of its cell and high for the remaining BIT_CLKS/2 clocks.
- R3: Inside a frame, `lineOut` changes level exactly once at the centre of every cell (clock BIT_CLKS/2 of the cell) and may otherwise change only at the first clock of a cell. BIT_CLKS is even and at least 4.
- R4: The first cell of every frame carries a 0 that is not part of the payload, so `lineOut` is low in the first cycle of `busy`.
- R5: The payload follows the leading cell, most significant bit first. For example, 0x34 is sent as 0,0,1,1,0,1,0,0.
- R6: While the block is idle and during reset, `lineOut`, `busy` and `done` are low.
- R7: A request is taken at a clock edge where `startReq` is high and `busy` is low. `busy` rises in the next cycle and stays high for exactly 9*BIT_CLKS cycles.
- R8: `done` is high for exactly one cycle, the first cycle after `busy` falls. `busy` is low in that cycle.
- R9: While `busy` is high, `startReq` and `txByte` have no effect on the frame being sent.
- R10: A request held high during the `done` cycle is taken at once, and the next frame starts with no idle cell between the two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to send `txByte` |
| txByte | input | DATA_W | Byte to send, sampled when the request is taken |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the last cell of a frame |
| lineOut | output | 1 | Manchester-coded serial line |

## Verification
The bench sends every possible byte value and decodes each frame from the line alone. It compares each sample with the level that cell should have, so a design that swapped the polarity of ones and zeros, moved the centre transition off BIT_CLKS/2, or sent bits least significant first would show up as bit or shape errors. Further frames raise `startReq` with a different byte at the first clock of a cell, at a cell centre, and near the end of a frame. A design that re-latched the input would corrupt the decoded byte or stretch `busy`. A back-to-back pair checks that a request held through the `done` cycle starts the next leading zero cell with no gap and no lost cell. An off-by-one cell counter would make `busy` too long or too short, or drop the final payload bit.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic load;    // latch a new frame into the shifter
    logic shift;   // advance to the next cell
    logic bitClk;  // low in the first half of a cell, high in the second
    logic active;  // a frame is on the line
  } mtxStrobe_t;

endpackage

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
#(
  parameter int BIT_CLKS   = 8,
  parameter int FRAME_BITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  output mtxStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int HALF = BIT_CLKS / 2;
  localparam int PW   = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int CW   = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [PW-1:0] phaseCnt;
  logic [CW-1:0] bitCnt;
  logic          busyQ;
  logic          doneQ;
  logic          accept;
  logic          lastPhase;
  logic          lastBit;

  assign accept    = startReq && !busyQ;
  assign lastPhase = (phaseCnt == PW'(BIT_CLKS - 1));
  assign lastBit   = (bitCnt == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      bitCnt   <= '0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ    <= 1'b1;
        phaseCnt <= '0;
        bitCnt   <= '0;
      end else if (busyQ) begin
        if (lastPhase) begin
          phaseCnt <= '0;
          if (lastBit) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load   = accept;
    strobe.shift  = busyQ && lastPhase;
    strobe.bitClk = busyQ && (phaseCnt >= PW'(HALF));
    strobe.active = busyQ;
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/mtx_datapath.sv
module mtx_datapath
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mtxStrobe_t        strobe,
  input  logic [DATA_W-1:0] txByte,
  output logic              lineOut
);

  // One extra cell ahead of the payload holds the sync zero.
  logic [DATA_W:0] shiftReg;
  logic            serBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= {1'b0, txByte};
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-1:0], 1'b0};
    end
  end

  assign serBit  = strobe.active & shiftReg[DATA_W];
  assign lineOut = serBit ^ strobe.bitClk;

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int BIT_CLKS = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [DATA_W-1:0] txByte,
  output logic              busy,
  output logic              done,
  output logic              lineOut
);

  localparam int FRAME_BITS = DATA_W + 1;

  mtxStrobe_t strobe;

  mtx_ctrl #(
    .BIT_CLKS  (BIT_CLKS),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startReq(startReq),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  mtx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .txByte (txByte),
    .lineOut(lineOut)
  );

endmodule

// File: rtl/mtx_tx_checker.sv
module mtx_tx_checker #(
  parameter int BIT_CLKS = 8,
  parameter int DATA_W   = 8
) (
  input logic clk,
  input logic rst_n,
  input logic startReq,
  input logic busy,
  input logic done,
  input logic lineOut
);

  localparam int HALF  = BIT_CLKS / 2;
  localparam int TOTAL = BIT_CLKS * (DATA_W + 1);
  localparam int PW    = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int LW    = $clog2(TOTAL + 1);

  // Independent cell-phase and frame-length counters, driven from the ports only.
  logic [PW-1:0] cyc;
  logic [LW-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= '0;
      busyLen <= '0;
    end else begin
      if (startReq && !busy) cyc <= '0;
      else if (busy) cyc <= (cyc == PW'(BIT_CLKS - 1)) ? '0 : cyc + 1'b1;
      busyLen <= busy ? busyLen + 1'b1 : '0;
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !lineOut);

  p_mid_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc == PW'(HALF)) |-> (lineOut != $past(lineOut)));

  p_half_flat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc != '0 && cyc != PW'(HALF)) |-> $stable(lineOut));

  p_sync_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !lineOut);

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busyLen) == LW'(TOTAL - 1)));

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_place_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a request while busy never restarts the cell phase.
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startReq && cyc != PW'(BIT_CLKS - 1)) |=> busy);

endmodule

bind manchester_tx mtx_tx_checker #(
  .BIT_CLKS(BIT_CLKS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .startReq(startReq),
  .busy    (busy),
  .done    (done),
  .lineOut (lineOut)
);

// File: tb/manchester_tx_test.sv
`timescale 1ns/1ps
module manchester_tx_test;

  localparam int N    = 6;
  localparam int W    = 8;
  localparam int HALF = N / 2;
  localparam int FB   = W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] txByte = '0;
  logic         busy;
  logic         done;
  logic         lineOut;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  manchester_tx #(.BIT_CLKS(N), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .txByte(txByte),
    .busy(busy), .done(done), .lineOut(lineOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send one frame and decode it from the line alone.
  task automatic runFrame(input logic [W-1:0] b, input int interfereAt,
                          input bit preStarted, input bit chain,
                          input logic [W-1:0] nextByte);
    logic [FB-1:0] frame;
    logic [FB-1:0] decoded;
    int err1, err0, midT, offT, busyErr;
    logic prev, s, expv;
    frame = {1'b0, b};
    decoded = '0;
    err1 = 0; err0 = 0; midT = 0; offT = 0; busyErr = 0;
    prev = 1'b0;
    if (!preStarted) begin
      @(negedge clk);
      startReq = 1'b1;
      txByte = b;
    end
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < FB * N; i++) begin
      int k;
      int j;
      logic fbit;
      k = i / N;
      j = i % N;
      fbit = frame[FB-1-k];
      if (i == interfereAt) begin startReq = 1'b1; txByte = ~b; end
      if (i == interfereAt + 1) startReq = 1'b0;
      s = lineOut;
      if (busy !== 1'b1) busyErr++;
      expv = (j < HALF) ? fbit : ~fbit;
      if (s !== expv) begin
        if (fbit) err1++; else err0++;
      end
      if (j == 0) decoded[FB-1-k] = s;
      if (i > 0 && s !== prev) begin
        if (j == HALF) midT++;
        else if (j != 0) offT++;
      end
      prev = s;
      @(negedge clk);
    end
    check(err1 == 0, "R1 one cells high-then-low", err1, 0);
    check(err0 == 0, "R2 zero cells low-then-high", err0, 0);
    check(midT == FB, "R3 centre transitions", midT, FB);
    check(offT == 0, "R3 off-centre transitions", offT, 0);
    check(decoded[FB-1] == 1'b0, "R4 leading sync cell", int'(decoded[FB-1]), 0);
    check(decoded[W-1:0] == b, "R5 payload MSB first", int'(decoded[W-1:0]), int'(b));
    if (interfereAt >= 0)
      check(decoded[W-1:0] == b, "R9 request while busy ignored", int'(decoded[W-1:0]), int'(b));
    if (preStarted)
      check(decoded == frame, "R10 back-to-back frame intact", int'(decoded), int'(frame));
    check(busyErr == 0, "R7 busy through frame", busyErr, 0);
    check(busy == 1'b0, "R7 busy falls after 9 cells", int'(busy), 0);
    check(done == 1'b1, "R8 done after last cell", int'(done), 1);
    if (chain) begin
      startReq = 1'b1;
      txByte = nextByte;
    end else begin
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", int'(done), 0);
      check(lineOut == 1'b0 && busy == 1'b0, "R6 idle line low", int'(lineOut), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    startReq = 1'b1;
    txByte = 8'hFF;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R6 reset busy low", int'(busy), 0);
    check(done == 1'b0, "R6 reset done low", int'(done), 0);
    check(lineOut == 1'b0, "R6 reset line low", int'(lineOut), 0);
    startReq = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(lineOut == 1'b0 && busy == 1'b0, "R6 idle after reset", int'(lineOut), 0);

    for (int v = 0; v < 256; v++) runFrame(v[7:0], -1, 1'b0, 1'b0, 8'h00);

    runFrame(8'h34, 0, 1'b0, 1'b0, 8'h00);
    runFrame(8'hA5, HALF, 1'b0, 1'b0, 8'h00);
    runFrame(8'h5A, 4 * N + 1, 1'b0, 1'b0, 8'h00);
    runFrame(8'h0F, FB * N - 2, 1'b0, 1'b0, 8'h00);

    runFrame(8'hC3, -1, 1'b0, 1'b1, 8'h3C);
    runFrame(8'h3C, -1, 1'b1, 1'b1, 8'h80);
    runFrame(8'h80, -1, 1'b1, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule